// File: doc/BRIEF.md
# Host Mailbox Port

This block is a two-sided mailbox between an external byte-wide host and the processor core. It holds six 16-bit data locations and two status locations, eight in all. The host reaches them through a 3-bit location number and sees the low byte. The core reaches them as memory-mapped 16-bit words. Host strobes are asynchronous to the core clock. They are brought into the core domain through a synchronizer before any register, flag or interrupt changes.

Each data location has two flags. The write-pending flag shows that the host has written data the core has not yet read. The read-pending flag shows that the core has written data the host has not yet read. Host writes raise a write interrupt pulse and completed host reads raise a read interrupt pulse. Each pulse is gated by a per-location mask bit and by a global enable. A reset-request bit, writable from either side, produces a software reset pulse of fixed length. Two mode pins select the host strobe style and whether the address has its own pins or shares the data bus.

All core and host accesses are single register transfers with no back-pressure, so the block has no valid/ready interface. The core side completes in one cycle and the host side is paced by its own strobes and the acknowledge.

Top module: `host_mailbox`

## Requirements
- R1: After reset, all eight locations read zero from the core, and `h_ack`, `irq_wr`, `irq_rd` and `soft_rst` are low.
- R2: Map: locations 0 to 5 are data. Location 6 holds the write-pending flags in bits [5:0]. Location 7 holds the read-pending flags in bits [5:0] and the reset request in bit 7. A host write of a byte to a data location stores it with the upper eight bits zero.
- R3: With `strobe_mode`=0, `h_rd_n` and `h_wr_n` are separate active-low read and write strobes. With `strobe_mode`=1, `h_wr_n` is an active-low data strobe and `h_rd_n` gives the direction (1 read, 0 write).
- R4: With `mux_mode`=1, the location number is taken from `h_ad_i[2:0]` at the falling edge of `h_ale`, and `h_addr` is ignored. With `mux_mode`=0 it is taken from `h_addr`.
- R5: A host write to data location i sets write-pending bit i. A core read of location i clears it.
- R6: A core write to data location i sets read-pending bit i. The end of a host read of location i clears it.
- R7: While a host read strobe is active, `h_ad_oe` is high and `h_ad_o` shows the low byte of the addressed location.
- R8: `irq_wr` pulses for one cycle after a host write to data location i only when `wr_mask[i]` and `wr_glb_en` are both 1.
- R9: `irq_rd` pulses for one cycle after a host read of data location i ends, only when `rd_mask[i]` and `rd_glb_en` are both 1.
- R10: Writing a 1 to bit 7 of location 7 from either side drives `soft_rst` high for exactly 5 cycles, and bit 7 reads 1 during that time. Writing location 7 with bit 7 at 0, or writing location 6, changes no flag and starts no pulse.
- R11: `h_ack` rises two core cycles after a host strobe becomes active. It falls two cycles after the strobe is removed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| strobe_mode | input | 1 | 0 separate strobes, 1 direction plus data strobe |
| mux_mode | input | 1 | 0 separate address pins, 1 address on data bus |
| h_sel_n | input | 1 | Host select, active low |
| h_rd_n | input | 1 | Read strobe or direction |
| h_wr_n | input | 1 | Write strobe or data strobe |
| h_ale | input | 1 | Address latch enable for shared bus |
| h_addr | input | 3 | Host location number (separate mode) |
| h_ad_i | input | 8 | Host data in, or address in shared mode |
| h_ad_o | output | 8 | Host read data |
| h_ad_oe | output | 1 | Host read data drive enable |
| h_ack | output | 1 | Access captured acknowledge |
| core_wr | input | 1 | Core write strobe |
| core_rd | input | 1 | Core read strobe (clears write-pending) |
| core_addr | input | 3 | Core location number |
| core_wdata | input | 16 | Core write data |
| core_rdata | output | 16 | Core read data |
| wr_mask | input | 6 | Per-location write interrupt masks |
| rd_mask | input | 6 | Per-location read interrupt masks |
| wr_glb_en | input | 1 | Global write interrupt enable |
| rd_glb_en | input | 1 | Global read interrupt enable |
| irq_wr | output | 1 | Write interrupt pulse |
| irq_rd | output | 1 | Read interrupt pulse |
| soft_rst | output | 1 | Software reset pulse |

## Verification
Host accesses are run under all four combinations of strobe style and address mode. The shared-bus case drives a different value on the separate address pins, which separates the latched address from the pin address. Traffic in both directions checks that each pending flag is set by one side and cleared only by the other. Mask and global-enable combinations show which of the two gates suppresses an interrupt. Reset requests from the host, from the core and with bit 7 clear separate a real request from a plain status write.

// File: rtl/hmbx_pkg.sv
package hmbx_pkg;
  localparam int unsigned NUM_DATA    = 6;
  localparam int unsigned DATA_W      = 16;
  localparam int unsigned HOST_W      = 8;
  localparam int unsigned ADDR_W      = 3;
  localparam int unsigned SRST_CYCLES = 5;
  localparam int unsigned SYNC_DEPTH  = 2;
  localparam int unsigned NUM_LOCS    = 1 << ADDR_W;
  localparam int unsigned WFLAG_LOC   = NUM_DATA;
  localparam int unsigned RFLAG_LOC   = NUM_DATA + 1;
  localparam int unsigned SRST_BIT    = 7;
endpackage

// File: rtl/hmbx_sync.sv
module hmbx_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < int'(STAGES); k++) st[k] <= '0;
    end else begin
      st[0] <= d;
      for (int k = 1; k < int'(STAGES); k++) st[k] <= st[k-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/hmbx_host_if.sv
module hmbx_host_if
  import hmbx_pkg::*;
#(
  parameter int unsigned STAGES = SYNC_DEPTH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe_mode,
  input  logic              mux_mode,
  input  logic              h_sel_n,
  input  logic              h_rd_n,
  input  logic              h_wr_n,
  input  logic              h_ale,
  input  logic [ADDR_W-1:0] h_addr,
  input  logic [HOST_W-1:0] h_ad_i,
  output logic              wr_act,
  output logic              rd_act,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              wr_evt,
  output logic              rd_done,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              ack
);
  logic [ADDR_W-1:0] lat_addr;
  logic [1:0]        sq;
  logic [1:0]        pq;

  // strobe decode, asynchronous to clk
  always_comb begin
    if (strobe_mode) begin
      rd_act = !h_sel_n && !h_wr_n && h_rd_n;
      wr_act = !h_sel_n && !h_wr_n && !h_rd_n;
    end else begin
      rd_act = !h_sel_n && !h_rd_n;
      wr_act = !h_sel_n && !h_wr_n;
    end
  end

  // shared-bus address captured as ALE falls
  always_ff @(negedge h_ale or negedge rst_n) begin
    if (!rst_n) lat_addr <= '0;
    else        lat_addr <= h_ad_i[ADDR_W-1:0];
  end

  assign cur_addr = mux_mode ? lat_addr : h_addr;

  hmbx_sync #(.W(2), .STAGES(STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({rd_act, wr_act}),
    .q    (sq)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pq      <= '0;
      rd_addr <= '0;
    end else begin
      pq <= sq;
      if (sq[1] && !pq[1]) rd_addr <= cur_addr;
    end
  end

  assign wr_evt  = sq[0] && !pq[0];
  assign rd_done = !sq[1] && pq[1];
  assign ack     = |sq;
endmodule

// File: rtl/hmbx_regs.sv
module hmbx_regs
  import hmbx_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                h_wr_evt,
  input  logic [ADDR_W-1:0]   h_wr_addr,
  input  logic [HOST_W-1:0]   h_wr_byte,
  input  logic                h_rd_done,
  input  logic [ADDR_W-1:0]   h_rd_addr,
  input  logic [ADDR_W-1:0]   h_peek_addr,
  output logic [HOST_W-1:0]   h_peek_byte,
  input  logic                core_wr,
  input  logic                core_rd,
  input  logic [ADDR_W-1:0]   core_addr,
  input  logic [DATA_W-1:0]   core_wdata,
  output logic [DATA_W-1:0]   core_rdata,
  input  logic                srst_active,
  output logic                srst_start,
  output logic [NUM_DATA-1:0] wr_hit,
  output logic [NUM_DATA-1:0] rd_hit
);
  logic [DATA_W-1:0]   dreg  [NUM_DATA];
  logic [DATA_W-1:0]   loc   [NUM_LOCS];
  logic [NUM_DATA-1:0] wflag;
  logic [NUM_DATA-1:0] rflag;

  for (genvar i = 0; i < int'(NUM_DATA); i++) begin : g_loc
    logic cw, cr, wf_q, rf_q;
    assign wr_hit[i] = h_wr_evt  && (h_wr_addr == ADDR_W'(i));
    assign rd_hit[i] = h_rd_done && (h_rd_addr == ADDR_W'(i));
    assign cw = core_wr && (core_addr == ADDR_W'(i));
    assign cr = core_rd && (core_addr == ADDR_W'(i));

    // host write wins over a core write in the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        dreg[i] <= '0;
        wf_q    <= 1'b0;
        rf_q    <= 1'b0;
      end else begin
        if (wr_hit[i])  dreg[i] <= {{(DATA_W-HOST_W){1'b0}}, h_wr_byte};
        else if (cw)    dreg[i] <= core_wdata;
        wf_q <= (wf_q && !cr) || wr_hit[i];
        rf_q <= (rf_q && !rd_hit[i]) || cw;
      end
    end

    assign wflag[i] = wf_q;
    assign rflag[i] = rf_q;
    assign loc[i]   = dreg[i];
  end

  assign loc[WFLAG_LOC] = DATA_W'(wflag);
  assign loc[RFLAG_LOC] = DATA_W'(rflag) | (DATA_W'(srst_active) << SRST_BIT);

  assign core_rdata  = loc[core_addr];
  assign h_peek_byte = loc[h_peek_addr][HOST_W-1:0];

  assign srst_start =
      (h_wr_evt && (h_wr_addr == ADDR_W'(RFLAG_LOC)) && h_wr_byte[SRST_BIT]) ||
      (core_wr  && (core_addr == ADDR_W'(RFLAG_LOC)) && core_wdata[SRST_BIT]);
endmodule

// File: rtl/hmbx_irq.sv
module hmbx_irq
  import hmbx_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_DATA-1:0] wr_hit,
  input  logic [NUM_DATA-1:0] rd_hit,
  input  logic [NUM_DATA-1:0] wr_mask,
  input  logic [NUM_DATA-1:0] rd_mask,
  input  logic                wr_glb_en,
  input  logic                rd_glb_en,
  output logic                irq_wr,
  output logic                irq_rd
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_wr <= 1'b0;
      irq_rd <= 1'b0;
    end else begin
      irq_wr <= wr_glb_en && |(wr_hit & wr_mask);
      irq_rd <= rd_glb_en && |(rd_hit & rd_mask);
    end
  end
endmodule

// File: rtl/hmbx_srst.sv
module hmbx_srst #(
  parameter int unsigned LEN = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic active
);
  localparam int unsigned CW = $clog2(LEN + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt <= '0;
    else if (cnt != '0)         cnt <= cnt - 1'b1;
    else if (start)             cnt <= CW'(LEN);
  end

  assign active = (cnt != '0);
endmodule

// File: rtl/host_mailbox.sv
module host_mailbox
  import hmbx_pkg::*;
#(
  parameter int unsigned SRST_LEN = SRST_CYCLES,
  parameter int unsigned SYNC_N   = SYNC_DEPTH
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                strobe_mode,
  input  logic                mux_mode,
  input  logic                h_sel_n,
  input  logic                h_rd_n,
  input  logic                h_wr_n,
  input  logic                h_ale,
  input  logic [ADDR_W-1:0]   h_addr,
  input  logic [HOST_W-1:0]   h_ad_i,
  output logic [HOST_W-1:0]   h_ad_o,
  output logic                h_ad_oe,
  output logic                h_ack,
  input  logic                core_wr,
  input  logic                core_rd,
  input  logic [ADDR_W-1:0]   core_addr,
  input  logic [DATA_W-1:0]   core_wdata,
  output logic [DATA_W-1:0]   core_rdata,
  input  logic [NUM_DATA-1:0] wr_mask,
  input  logic [NUM_DATA-1:0] rd_mask,
  input  logic                wr_glb_en,
  input  logic                rd_glb_en,
  output logic                irq_wr,
  output logic                irq_rd,
  output logic                soft_rst
);
  logic                host_wr_act, host_rd_act;
  logic [ADDR_W-1:0]   host_addr, host_rd_addr;
  logic                host_wr_evt, host_rd_done;
  logic                srst_start;
  logic [NUM_DATA-1:0] wr_hit, rd_hit;

  hmbx_host_if #(.STAGES(SYNC_N)) u_hif (
    .clk(clk), .rst_n(rst_n),
    .strobe_mode(strobe_mode), .mux_mode(mux_mode),
    .h_sel_n(h_sel_n), .h_rd_n(h_rd_n), .h_wr_n(h_wr_n), .h_ale(h_ale),
    .h_addr(h_addr), .h_ad_i(h_ad_i),
    .wr_act(host_wr_act), .rd_act(host_rd_act), .cur_addr(host_addr),
    .wr_evt(host_wr_evt), .rd_done(host_rd_done), .rd_addr(host_rd_addr),
    .ack(h_ack)
  );

  hmbx_regs u_regs (
    .clk(clk), .rst_n(rst_n),
    .h_wr_evt(host_wr_evt), .h_wr_addr(host_addr), .h_wr_byte(h_ad_i),
    .h_rd_done(host_rd_done), .h_rd_addr(host_rd_addr),
    .h_peek_addr(host_addr), .h_peek_byte(h_ad_o),
    .core_wr(core_wr), .core_rd(core_rd), .core_addr(core_addr),
    .core_wdata(core_wdata), .core_rdata(core_rdata),
    .srst_active(soft_rst), .srst_start(srst_start),
    .wr_hit(wr_hit), .rd_hit(rd_hit)
  );

  hmbx_irq u_irq (
    .clk(clk), .rst_n(rst_n),
    .wr_hit(wr_hit), .rd_hit(rd_hit),
    .wr_mask(wr_mask), .rd_mask(rd_mask),
    .wr_glb_en(wr_glb_en), .rd_glb_en(rd_glb_en),
    .irq_wr(irq_wr), .irq_rd(irq_rd)
  );

  hmbx_srst #(.LEN(SRST_LEN)) u_srst (
    .clk(clk), .rst_n(rst_n), .start(srst_start), .active(soft_rst)
  );

  assign h_ad_oe = host_rd_act;
endmodule

// File: rtl/hmbx_checker.sv
module hmbx_checker (
  input logic clk,
  input logic rst_n,
  input logic h_ack,
  input logic host_wr_act,
  input logic host_rd_act,
  input logic irq_wr,
  input logic irq_rd,
  input logic wr_glb_en,
  input logic rd_glb_en,
  input logic soft_rst
);
  int unsigned run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        run <= 0;
    else if (soft_rst) run <= run + 1;
    else               run <= 0;
  end

  AST_SRST_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(soft_rst) |-> (run == 5)); // R10
  AST_SRST_NO_STRETCH: assert property (@(posedge clk) disable iff (!rst_n)
    run <= 5); // R10
  AST_IRQ_WR_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    irq_wr |-> $past(wr_glb_en)); // R8
  AST_IRQ_RD_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    irq_rd |-> $past(rd_glb_en)); // R9
  AST_IRQ_WR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_wr |=> !irq_wr); // R8
  AST_ACK_LAG: assert property (@(posedge clk) disable iff (!rst_n)
    h_ack |-> $past(host_wr_act || host_rd_act, 2)); // R11
endmodule

bind host_mailbox hmbx_checker u_chk (
  .clk(clk), .rst_n(rst_n), .h_ack(h_ack),
  .host_wr_act(host_wr_act), .host_rd_act(host_rd_act),
  .irq_wr(irq_wr), .irq_rd(irq_rd),
  .wr_glb_en(wr_glb_en), .rd_glb_en(rd_glb_en),
  .soft_rst(soft_rst)
);

// File: tb/sim_host_mailbox.sv
`timescale 1ns/1ps
module sim_host_mailbox;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        strobe_mode = 1'b0, mux_mode = 1'b0;
  logic        h_sel_n = 1'b1, h_rd_n = 1'b1, h_wr_n = 1'b1, h_ale = 1'b0;
  logic [2:0]  h_addr = '0;
  logic [7:0]  h_ad_i = '0;
  logic [7:0]  h_ad_o;
  logic        h_ad_oe, h_ack;
  logic        core_wr = 1'b0, core_rd = 1'b0;
  logic [2:0]  core_addr = '0;
  logic [15:0] core_wdata = '0;
  logic [15:0] core_rdata;
  logic [5:0]  wr_mask = '1, rd_mask = '1;
  logic        wr_glb_en = 1'b1, rd_glb_en = 1'b1;
  logic        irq_wr, irq_rd, soft_rst;

  int n_chk = 0, n_bad = 0;
  int n_irq_wr = 0, n_irq_rd = 0;
  int srst_cur = 0, srst_last = 0, srst_pulses = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  host_mailbox u0 (.*);

  always @(negedge clk) begin
    if (irq_wr) n_irq_wr++;
    if (irq_rd) n_irq_rd++;
    if (soft_rst) srst_cur++;
    else if (srst_cur != 0) begin srst_last = srst_cur; srst_pulses++; srst_cur = 0; end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic core_write(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); core_addr = a; core_wdata = d; core_wr = 1'b1;
    @(negedge clk); core_wr = 1'b0;
  endtask

  task automatic core_read(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk); core_addr = a; core_rd = 1'b1; #1 d = core_rdata;
    @(negedge clk); core_rd = 1'b0;
  endtask

  task automatic host_access(input bit is_wr, input logic [2:0] a, input logic [7:0] wd,
                             output logic [7:0] rd, output bit oe, output bit ack);
    @(negedge clk);
    if (mux_mode) begin
      h_addr = ~a; h_ad_i = {5'b0, a}; h_ale = 1'b1;
      @(negedge clk); h_ale = 1'b0;
      @(negedge clk);
    end else h_addr = a;
    h_ad_i = wd;
    h_sel_n = 1'b0;
    if (strobe_mode) begin h_rd_n = !is_wr; h_wr_n = 1'b0; end
    else if (is_wr) h_wr_n = 1'b0;
    else h_rd_n = 1'b0;
    repeat (4) @(negedge clk);
    ack = h_ack; rd = h_ad_o; oe = h_ad_oe;
    h_sel_n = 1'b1; h_wr_n = 1'b1; h_rd_n = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [15:0] d;
    chk(!h_ack && !irq_wr && !irq_rd && !soft_rst, "R1 outputs", {h_ack, irq_wr, irq_rd, soft_rst}, 0);
    for (int i = 0; i < 8; i++) begin
      core_read(3'(i), d);
      chk(d == 16'h0, "R1 location", d, 0);
    end
  endtask

  task automatic t_ack;
    @(negedge clk); strobe_mode = 0; mux_mode = 0; h_addr = 3'd0; h_ad_i = 8'h11;
    h_sel_n = 1'b0; h_wr_n = 1'b0;
    @(negedge clk); chk(h_ack == 1'b0, "R11 ack one cycle", h_ack, 0);
    @(negedge clk); chk(h_ack == 1'b1, "R11 ack two cycles", h_ack, 1);
    h_sel_n = 1'b1; h_wr_n = 1'b1;
    @(negedge clk); chk(h_ack == 1'b1, "R11 ack held", h_ack, 1);
    @(negedge clk); chk(h_ack == 1'b0, "R11 ack released", h_ack, 0);
    repeat (3) @(negedge clk);
    core_read_clear(3'd0);
  endtask

  task automatic core_read_clear(input logic [2:0] a);
    logic [15:0] d;
    core_read(a, d);
  endtask

  task automatic t_sep_write;
    logic [15:0] d; logic [7:0] r; bit oe, ack; int w0;
    strobe_mode = 0; mux_mode = 0; w0 = n_irq_wr;
    host_access(1, 3'd2, 8'hA5, r, oe, ack);
    chk(ack, "R11 ack on write", ack, 1);
    chk(n_irq_wr == w0 + 1, "R8 write irq", n_irq_wr - w0, 1);
    core_read(3'd6, d); chk(d == 16'h0004, "R5 write flag set", d, 16'h0004);
    core_read(3'd2, d); chk(d == 16'h00A5, "R2 zero fill", d, 16'h00A5);
    core_read(3'd6, d); chk(d == 16'h0000, "R5 write flag cleared", d, 0);
  endtask

  task automatic t_ds_mode;
    logic [15:0] d; logic [7:0] r; bit oe, ack;
    strobe_mode = 1; mux_mode = 0;
    host_access(1, 3'd4, 8'h3C, r, oe, ack);
    core_read(3'd4, d); chk(d == 16'h003C, "R3 data strobe write", d, 16'h003C);
    host_access(0, 3'd4, 8'h00, r, oe, ack);
    chk(r == 8'h3C && oe, "R3 data strobe read", r, 8'h3C);
    strobe_mode = 0;
  endtask

  task automatic t_mux;
    logic [15:0] d; logic [7:0] r; bit oe, ack;
    mux_mode = 1; strobe_mode = 0;
    host_access(1, 3'd5, 8'h81, r, oe, ack);
    core_read(3'd5, d); chk(d == 16'h0081, "R4 latched address", d, 16'h0081);
    core_read(3'd2, d); chk(d == 16'h00A5, "R4 pin address ignored", d, 16'h00A5);
    strobe_mode = 1;
    host_access(0, 3'd5, 8'h00, r, oe, ack);
    chk(r == 8'h81, "R4 shared bus read", r, 8'h81);
    mux_mode = 0; strobe_mode = 0;
  endtask

  task automatic t_core_to_host;
    logic [15:0] d; logic [7:0] r; bit oe, ack; int r0;
    core_write(3'd1, 16'hBEEF);
    host_access(0, 3'd7, 8'h00, r, oe, ack);
    chk(r == 8'h02, "R6 read flag set", r, 8'h02);
    r0 = n_irq_rd;
    host_access(0, 3'd1, 8'h00, r, oe, ack);
    chk(r == 8'hEF, "R7 read data", r, 8'hEF);
    chk(oe, "R7 output enable", oe, 1);
    chk(!h_ad_oe, "R7 output enable released", h_ad_oe, 0);
    chk(n_irq_rd == r0 + 1, "R9 read irq", n_irq_rd - r0, 1);
    core_read(3'd7, d); chk(d == 16'h0000, "R6 read flag cleared", d, 0);
  endtask

  task automatic t_masks;
    logic [7:0] r; bit oe, ack; int w0, r0;
    w0 = n_irq_wr; r0 = n_irq_rd;
    wr_mask = 6'b110111;
    host_access(1, 3'd3, 8'h01, r, oe, ack);
    chk(n_irq_wr == w0, "R8 masked location", n_irq_wr - w0, 0);
    wr_mask = '1; wr_glb_en = 0;
    host_access(1, 3'd3, 8'h02, r, oe, ack);
    chk(n_irq_wr == w0, "R8 global disabled", n_irq_wr - w0, 0);
    wr_glb_en = 1;
    host_access(1, 3'd3, 8'h03, r, oe, ack);
    chk(n_irq_wr == w0 + 1, "R8 both set", n_irq_wr - w0, 1);
    rd_mask = 6'b111110;
    host_access(0, 3'd0, 8'h00, r, oe, ack);
    chk(n_irq_rd == r0, "R9 masked location", n_irq_rd - r0, 0);
    rd_mask = '1; rd_glb_en = 0;
    host_access(0, 3'd0, 8'h00, r, oe, ack);
    chk(n_irq_rd == r0, "R9 global disabled", n_irq_rd - r0, 0);
    rd_glb_en = 1;
    core_read_clear(3'd3);
  endtask

  task automatic t_srst;
    logic [15:0] d; logic [7:0] r; bit oe, ack; int p0;
    p0 = srst_pulses;
    core_write(3'd7, 16'h0080);
    core_read(3'd7, d); chk(d[7] == 1'b1, "R10 request bit visible", d, 16'h0080);
    repeat (8) @(negedge clk);
    chk(srst_pulses == p0 + 1 && srst_last == 5, "R10 core pulse width", srst_last, 5);
    host_access(1, 3'd7, 8'h80, r, oe, ack);
    repeat (6) @(negedge clk);
    chk(srst_pulses == p0 + 2 && srst_last == 5, "R10 host pulse width", srst_last, 5);
    core_write(3'd1, 16'h1234);
    core_write(3'd7, 16'h007F);
    host_access(1, 3'd6, 8'hFF, r, oe, ack);
    repeat (8) @(negedge clk);
    chk(srst_pulses == p0 + 2, "R10 no request", srst_pulses - p0, 2);
    core_read(3'd7, d); chk(d == 16'h0002, "R10 flags kept", d, 16'h0002);
    core_read(3'd6, d); chk(d == 16'h0000, "R10 write flags kept", d, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_ack;
    t_sep_write;
    t_ds_mode;
    t_mux;
    t_core_to_host;
    t_masks;
    t_srst;
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule